// File: doc/BRIEF.md
# Segmented Prefix Carry-Select Adder

This block adds two wide unsigned operands and a carry-in. The operand width is cut into a number of equal slices, and every slice is the same replicated module. Each slice computes its sum twice at once, with two parallel-prefix adders: one assumes that no carry arrives from below, and the other assumes that a carry arrives. Only one carry bit crosses each slice boundary. That bit picks the finished result of the slice above, so the critical path is one prefix tree of slice width plus one multiplexer step per slice.

The total width and the slice count are parameters. Widths from 512 to 4096 bits are intended. Elaboration stops on any configuration where the width does not divide evenly into slices, or where the slice width is not a power of two of at least 2. A parameter selects whether the result leaves through a register or straight from the logic.

Top module: `wide_psel_adder`

## Requirements
- R1: With the output register enabled, `sum_o` and `cout_o` on the cycle after a rising clock edge equal the low WIDTH bits and bit WIDTH of `a_i + b_i + cin_i` sampled at that edge.
- R2: With the output register enabled, a rising edge that sees `rst_n` low clears `sum_o` to all zeros and `cout_o` to 0.
- R3: The carry leaving slice i equals bit (i+1)*SW of the exact sum of the lower (i+1)*SW operand bits plus `cin_i`, where SW = WIDTH/SEGS. This holds wherever in the word a carry is generated.
- R4: A slice whose operand bits are complementary in every position passes its incoming carry straight to the next slice. For example, all-ones plus zero with `cin_i`=1 gives a sum of zero and `cout_o`=1, and so does all-ones plus one with `cin_i`=0.
- R5: With the output register disabled, the outputs follow the inputs in the same cycle with the same arithmetic as R1. This holds for other width and slice-count settings as well.
- R6: Zero plus zero with `cin_i`=1 gives a sum of 1 and `cout_o`=0.
- R7: All-ones plus all-ones with `cin_i`=1 gives a sum of all ones and `cout_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous reset, active low |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum, low WIDTH bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
A wrong boundary carry, or a wrong choice between a slice's two results, corrupts every bit from the faulty slice boundary upward. It can also flip `cout_o`. Because the block holds no state beyond the output register, the fault shows on the very next registered output, or in the same cycle in the unregistered variant. The stimulus therefore places carry generation at each slice boundary in turn, over fully propagating upper slices, so that every boundary carry can be seen at the ports.

// File: rtl/wsa_pkg.sv
// Package: shared generate/propagate type and helpers for the wide adder.
// Assumes: single-bit prefix nodes; no state.
package wsa_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Prefix operator: combine a higher group (hi) with the adjacent lower one (lo).
    function automatic gp_t gp_dot(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // True when v is a power of two and at least 2.
    function automatic bit pow2_ok(input int v);
        return (v >= 2) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/ks_adder.sv
// Module: ks_adder
// Parallel-prefix (Kogge-Stone) adder of W bits with a carry-in fixed at
// elaboration. Assumes W is a power of two >= 2. Purely combinational.
module ks_adder #(
    parameter int   W   = 16,
    parameter logic CIN = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);
    import wsa_pkg::*;

    localparam int LVL = $clog2(W);

    logic [W-1:0] g_lv [LVL+1];
    logic [W-1:0] p_lv [LVL+1];
    logic [W:0]   carry;

    // Bitwise generate and propagate seed the tree.
    assign g_lv[0] = a & b;
    assign p_lv[0] = a ^ b;

    // Each level doubles the span of every group.
    for (genvar l = 0; l < LVL; l++) begin : g_level
        for (genvar i = 0; i < W; i++) begin : g_node
            if (i >= (1 << l)) begin : g_comb
                assign {g_lv[l+1][i], p_lv[l+1][i]} =
                    gp_dot('{g: g_lv[l][i], p: p_lv[l][i]},
                           '{g: g_lv[l][i-(1<<l)], p: p_lv[l][i-(1<<l)]});
            end else begin : g_pass
                assign g_lv[l+1][i] = g_lv[l][i];
                assign p_lv[l+1][i] = p_lv[l][i];
            end
        end
    end

    // Carry into each bit folds in the fixed carry-in.
    assign carry[0] = CIN;
    for (genvar i = 0; i < W; i++) begin : g_carry
        assign carry[i+1] = g_lv[LVL][i] | (p_lv[LVL][i] & CIN);
    end

    assign sum  = p_lv[0] ^ carry[W-1:0];
    assign cout = carry[W];

endmodule

// File: rtl/seg_pair.sv
// Module: seg_pair
// One slice: two prefix adders run side by side (carry-in 0 and 1); the
// incoming boundary carry selects the sum and the outgoing carry.
// Assumes SW is a power of two >= 2. Purely combinational.
module seg_pair #(
    parameter int SW = 16
) (
    input  logic [SW-1:0] a,
    input  logic [SW-1:0] b,
    input  logic          c_in,
    output logic [SW-1:0] sum,
    output logic          c_out
);
    logic [SW-1:0] sum_z, sum_o1;
    logic          co_z, co_o1;

    ks_adder #(.W(SW), .CIN(1'b0)) u_add_z (
        .a(a), .b(b), .sum(sum_z), .cout(co_z)
    );

    ks_adder #(.W(SW), .CIN(1'b1)) u_add_o (
        .a(a), .b(b), .sum(sum_o1), .cout(co_o1)
    );

    // Late-arriving carry picks the precomputed result.
    always_comb begin
        sum   = c_in ? sum_o1 : sum_z;
        c_out = co_z | (co_o1 & c_in);
    end

endmodule

// File: rtl/wide_psel_adder.sv
// Module: wide_psel_adder
// WIDTH-bit adder built from SEGS identical slices; one carry bit per
// boundary forms the chain. REG_OUT=1 adds an output register with
// synchronous active-low reset. Assumes WIDTH % SEGS == 0 and WIDTH/SEGS
// a power of two >= 2 (checked at elaboration).
module wide_psel_adder #(
    parameter int WIDTH   = 512,
    parameter int SEGS    = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    import wsa_pkg::*;

    localparam int SW = WIDTH / SEGS;

    // Reject unsupported shapes while elaborating.
    if ((WIDTH % SEGS) != 0) begin : g_bad_div
        $error("wide_psel_adder: WIDTH must be a multiple of SEGS");
    end
    if (!pow2_ok(SW)) begin : g_bad_sw
        $error("wide_psel_adder: WIDTH/SEGS must be a power of two >= 2");
    end

    logic [SEGS:0]    seg_c;
    logic [WIDTH-1:0] sum_d;

    assign seg_c[0] = cin_i;

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        seg_pair #(.SW(SW)) u_seg (
            .a    (a_i[s*SW +: SW]),
            .b    (b_i[s*SW +: SW]),
            .c_in (seg_c[s]),
            .sum  (sum_d[s*SW +: SW]),
            .c_out(seg_c[s+1])
        );
    end

    if (REG_OUT) begin : g_reg
        // Capture the result; clear on synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum_o  <= '0;
                cout_o <= 1'b0;
            end else begin
                sum_o  <= sum_d;
                cout_o <= seg_c[SEGS];
            end
        end
    end else begin : g_comb
        // Drive the result straight out.
        always_comb begin
            sum_o  = sum_d;
            cout_o = seg_c[SEGS];
        end
    end

endmodule

// File: rtl/wsa_chk.sv
// Module: wsa_chk
// Assertion checker bound to wide_psel_adder. Observes ports and the
// boundary carry chain.
module wsa_chk #(
    parameter int WIDTH   = 512,
    parameter int SEGS    = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o,
    input logic [SEGS:0]    seg_c
);
    localparam int SW = WIDTH / SEGS;

    logic [WIDTH:0] ref_sum;
    assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

    if (REG_OUT) begin : g_reg_chk
        AST_REG_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> ({cout_o, sum_o} == $past(ref_sum))); // R1
        AST_RESET_CLEAR: assert property (@(posedge clk)
            !rst_n |=> (sum_o == '0 && cout_o == 1'b0)); // R2
    end else begin : g_comb_chk
        // Unregistered result must match the inputs of the same cycle.
        always @(posedge clk) begin
            if (rst_n) begin
                AST_COMB_RESULT: assert ({cout_o, sum_o} == ref_sum); // R5
            end
        end
    end

    for (genvar i = 0; i < SEGS; i++) begin : g_bnd
        logic [(i+1)*SW:0] low_sum;
        assign low_sum = {1'b0, a_i[(i+1)*SW-1:0]} + {1'b0, b_i[(i+1)*SW-1:0]}
                       + {{((i+1)*SW){1'b0}}, cin_i};
        // Boundary carry against the exact lower-bit sum; propagate-only slices pass it on.
        always @(posedge clk) begin
            if (rst_n) begin
                AST_BOUNDARY_CARRY: assert (seg_c[i+1] == low_sum[(i+1)*SW]); // R3
                if (&(a_i[i*SW +: SW] ^ b_i[i*SW +: SW])) begin
                    AST_PROPAGATE_PASS: assert (seg_c[i+1] == seg_c[i]); // R4
                end
            end
        end
    end

endmodule

bind wide_psel_adder wsa_chk #(.WIDTH(WIDTH), .SEGS(SEGS), .REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
    .sum_o(sum_o), .cout_o(cout_o), .seg_c(seg_c)
);

// File: tb/sim_wide_psel_adder.sv
`timescale 1ns/1ps
// Bench for wide_psel_adder: u0 is registered (512 bits, 32 slices),
// u1 is combinational (64 bits, 4 slices) and sees the low operand bits.
module sim_wide_psel_adder;
    localparam int N  = 512;
    localparam int K  = 32;
    localparam int SW = N / K;
    localparam int N1 = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] a = '0, b = '0;
    logic         cin = 1'b0;
    logic [N-1:0] sum0;
    logic         cout0;
    logic [N1-1:0] sum1;
    logic          cout1;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    wide_psel_adder #(.WIDTH(N), .SEGS(K), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum0), .cout_o(cout0)
    );

    wide_psel_adder #(.WIDTH(N1), .SEGS(4), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .a_i(a[N1-1:0]), .b_i(b[N1-1:0]), .cin_i(cin),
        .sum_o(sum1), .cout_o(cout1)
    );

    task automatic check(input string req, input logic [N:0] act, input logic [N:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] rnd();
        logic [N-1:0] r;
        for (int w = 0; w < N / 32; w++) r[w*32 +: 32] = $urandom();
        return r;
    endfunction

    // Apply one vector just after a falling edge; check u1 now, u0 one edge later.
    task automatic run(input logic [N-1:0] av, input logic [N-1:0] bv,
                       input logic cv, input string req);
        logic [N:0]    exp0;
        logic [N1:0]   exp1;
        a = av; b = bv; cin = cv;
        exp0 = {1'b0, av} + {1'b0, bv} + {{N{1'b0}}, cv};
        exp1 = {1'b0, av[N1-1:0]} + {1'b0, bv[N1-1:0]} + {{N1{1'b0}}, cv};
        #1;
        check({"R5 ", req}, {{(N-N1){1'b0}}, cout1, sum1}, {{(N-N1){1'b0}}, exp1});
        @(posedge clk);
        @(negedge clk);
        check({"R1 ", req}, {cout0, sum0}, exp0);
    endtask

    initial begin
        logic [N-1:0] ones;
        ones = '1;
        // R2: reset with busy inputs must leave zeros.
        a = ones; b = ones; cin = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 reset", {cout0, sum0}, '0);
        rst_n = 1'b1;

        run('0, '0, 1'b1, "R6 zero plus carry");
        run(ones, '0, 1'b1, "R4 ones plus cin");
        run(ones, {{(N-1){1'b0}}, 1'b1}, 1'b0, "R4 ones plus one");
        run({(N/4){4'h5}}, {(N/4){4'hA}}, 1'b1, "R4 alternating propagate");
        run(ones, ones, 1'b1, "R7 max operands");
        run(ones, ones, 1'b0, "R7 max operands no cin");

        // R3: carry generated at the base of each slice, all bits above propagate.
        for (int j = 0; j < K; j++) begin
            logic [N-1:0] ra, rb;
            ra = rnd();
            rb = ~ra;
            ra[j*SW] = 1'b1;
            rb[j*SW] = 1'b1;
            run(ra, rb, 1'b0, "R3 boundary carry");
        end

        // R2: reset mid-run clears the register.
        a = ones; b = ones; cin = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R2 mid-run reset", {cout0, sum0}, '0);
        rst_n = 1'b1;

        // R1: random operands.
        for (int n = 0; n < 200; n++) begin
            run(rnd(), rnd(), 1'($urandom() & 1), "random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule